// File: doc/BRIEF.md
# Fuse Record Stream Decoder

This block expands a compacted one-time-programmable fuse image into a flat logical configuration map. After a start pulse it first erases the whole logical map by writing 0xFF to every byte. It then walks the physical image from address zero, reading one byte at a time, and decodes a chain of variable-length records. Each record opens with a one-byte or two-byte header that names a block and carries four active-low word-present flags. The two-byte words that follow are scattered into the logical map at positions derived from the block number and word slot.

The physical image sits behind a byte read port whose data returns on the clock after the request. The logical map is fed through a valid/ready byte write port. The block raises `wr_valid` with an address and a data byte and holds all three unchanged until it sees `wr_ready` high at a clock edge. The consumer may hold `wr_ready` low for any number of cycles, and the decoder stalls without losing or reordering bytes. Control is a plain start pulse, a one-cycle done pulse and an error level.

Top module: `fuse_rec_decoder`

## Requirements
- R1: After a start, every logical address from 0 to LOG_SIZE-1 is written with 0xFF before any decoded data byte is written.
- R2: A header byte whose low five bits are not 0x0F is a one-byte header: block = byte[7:4], present flags = byte[3:0].
- R3: A header byte whose low five bits equal 0x0F begins a two-byte header: block = {second[7:4], first[7:5]}, present flags = second[3:0].
- R4: Flag bit i equal to 0 means word i is present. Present words are taken in ascending i, and each consumes the next two physical bytes in order.
- R5: Word i of block b goes to logical address b*8+2i (first byte) and b*8+2i+1 (second byte).
- R6: A header byte of 0xFF, or a two-byte header whose second byte is 0xFF, ends the scan with `err` low.
- R7: Only physical addresses below LIMIT = PHY_SIZE-PROT_SIZE are read. A header position equal to LIMIT ends the scan with no error, and so does a two-byte header whose second byte would sit at LIMIT.
- R8: A present word whose second byte would lie at or above LIMIT ends the scan with `err` high, and that word is not written.
- R9: A present word whose second logical byte would lie at or above LOG_SIZE ends the scan with `err` high, and that word is not written.
- R10: `done` is high for exactly one cycle per scan. `err` is valid in that cycle and holds until the next accepted start. A start while a scan runs is ignored.
- R11: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` stay unchanged in the next cycle. The decoded map does not depend on the `wr_ready` pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan (accepted only when idle) |
| done | output | 1 | One-cycle end-of-scan pulse |
| err | output | 1 | Scan ended on a bound violation |
| rd_en | output | 1 | Physical read request |
| rd_addr | output | PA_W | Physical byte address |
| rd_data | input | 8 | Physical byte, valid the cycle after `rd_en` |
| wr_valid | output | 1 | Logical write offered |
| wr_ready | input | 1 | Logical write accepted at this edge when high |
| wr_addr | output | LA_W | Logical byte address |
| wr_data | output | 8 | Logical byte value |

## Verification
The bench targets the boundaries of the scan window. It places a header exactly at the limit, a two-byte header straddling it, and a two-word record whose second word runs past it. A design with an off-by-one would read the forbidden tail, decode garbage as a header, or write the overflowing word. A two-byte header whose block lands past the logical map checks that the error is raised before the write, because a design that tests the bound too late would corrupt low addresses through the address wrap. Inverted flag polarity or a wrong block bit order shows up as data at the wrong logical addresses. A restart during a scan shows up as a surplus of erase writes. Back-pressure on the write port checks that a stalled byte is neither dropped nor repeated.

// File: rtl/fuse_rec_pkg.sv
package fuse_rec_pkg;

  localparam int          SLOTS     = 4;      // word slots per block
  localparam int          BLK_W     = 7;      // block index width
  localparam logic [7:0]  ERASED    = 8'hFF;  // unprogrammed byte value
  localparam logic [4:0]  LONG_MARK = 5'h0F;  // low bits flagging a two-byte header

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_HDR1,
    ST_HDR1_W,
    ST_HDR2_W,
    ST_WORD,
    ST_DATA_W,
    ST_WRITE,
    ST_DONE
  } walk_st_t;

endpackage

// File: rtl/fuse_hdr_decode.sv
module fuse_hdr_decode
  import fuse_rec_pkg::*;
(
  input  logic [7:0]       first_b,
  input  logic [7:0]       second_b,
  output logic             long_fmt,
  output logic             end_short,
  output logic             end_long,
  output logic [BLK_W-1:0] blk,
  output logic [SLOTS-1:0] absent
);

  assign long_fmt  = (first_b[4:0] == LONG_MARK);
  assign end_short = (first_b == ERASED);
  assign end_long  = (second_b == ERASED);

  always_comb begin
    if (long_fmt) begin
      blk    = {second_b[7:4], first_b[7:5]};
      absent = second_b[3:0];
    end else begin
      blk    = {3'b000, first_b[7:4]};
      absent = first_b[3:0];
    end
  end

endmodule

// File: rtl/fuse_word_pick.sv
module fuse_word_pick #(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  present,
  output logic          any,
  output logic [IW-1:0] idx
);

  logic [N-1:0] first_hot;

  // one-hot of the lowest present slot
  for (genvar g = 0; g < N; g++) begin : g_hot
    if (g == 0) begin : g_lo
      assign first_hot[g] = present[g];
    end else begin : g_hi
      assign first_hot[g] = present[g] & ~(|present[g-1:0]);
    end
  end

  assign any = |present;

  always_comb begin
    idx = '0;
    for (int k = 0; k < N; k++) begin
      if (first_hot[k]) idx = idx | IW'(k);
    end
  end

endmodule

// File: rtl/fuse_rec_decoder.sv
module fuse_rec_decoder
  import fuse_rec_pkg::*;
#(
  parameter int PHY_SIZE  = 256,
  parameter int PROT_SIZE = 16,
  parameter int LOG_SIZE  = 128,
  parameter int PA_W      = $clog2(PHY_SIZE),
  parameter int LA_W      = $clog2(LOG_SIZE)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            done,
  output logic            err,
  output logic            rd_en,
  output logic [PA_W-1:0] rd_addr,
  input  logic [7:0]      rd_data,
  output logic            wr_valid,
  input  logic            wr_ready,
  output logic [LA_W-1:0] wr_addr,
  output logic [7:0]      wr_data
);

  localparam int LIMIT = PHY_SIZE - PROT_SIZE;
  localparam int PW    = PA_W + 2;
  localparam int LX    = (LA_W + 1 > 11) ? LA_W + 1 : 11;
  localparam int SW    = $clog2(SLOTS);

  walk_st_t         st_q;
  logic [PW-1:0]    ptr_q;
  logic [LA_W-1:0]  clr_q;
  logic [7:0]       hdr1_q;
  logic [BLK_W-1:0] blk_q;
  logic [SLOTS-1:0] absent_q;
  logic [LX-1:0]    log_q;
  logic [7:0]       dat_q;
  logic             sec_q;
  logic             err_q;

  // header decode
  logic [7:0]       dec_first;
  logic             dec_long, dec_end1, dec_end2;
  logic [BLK_W-1:0] dec_blk;
  logic [SLOTS-1:0] dec_absent;

  assign dec_first = (st_q == ST_HDR2_W) ? hdr1_q : rd_data;

  fuse_hdr_decode u_hdr (
    .first_b  (dec_first),
    .second_b (rd_data),
    .long_fmt (dec_long),
    .end_short(dec_end1),
    .end_long (dec_end2),
    .blk      (dec_blk),
    .absent   (dec_absent)
  );

  // next present word slot
  logic          pick_any;
  logic [SW-1:0] pick_idx;

  fuse_word_pick #(.N(SLOTS), .IW(SW)) u_pick (
    .present(~absent_q),
    .any    (pick_any),
    .idx    (pick_idx)
  );

  // bound arithmetic
  logic [PW-1:0] ptr_p1, ptr_p2;
  logic [LX-1:0] log_addr;
  logic          at_limit, hdr2_fits, data_fits, log_fits;
  logic          wr_fire;

  assign ptr_p1    = ptr_q + PW'(1);
  assign ptr_p2    = ptr_q + PW'(2);
  assign log_addr  = LX'({blk_q, 3'b000}) + LX'({pick_idx, 1'b0});
  assign at_limit  = (ptr_q >= PW'(LIMIT));
  assign hdr2_fits = (ptr_p1 < PW'(LIMIT));
  assign data_fits = (ptr_p2 <= PW'(LIMIT));
  assign log_fits  = ((log_addr + LX'(2)) <= LX'(LOG_SIZE));
  assign wr_fire   = wr_valid & wr_ready;

  // physical read requests
  always_comb begin
    rd_en   = 1'b0;
    rd_addr = '0;
    case (st_q)
      ST_HDR1: if (!at_limit) begin
        rd_en   = 1'b1;
        rd_addr = ptr_q[PA_W-1:0];
      end
      ST_HDR1_W: if (!dec_end1 && dec_long && hdr2_fits) begin
        rd_en   = 1'b1;
        rd_addr = ptr_p1[PA_W-1:0];
      end
      ST_WORD: if (pick_any && data_fits && log_fits) begin
        rd_en   = 1'b1;
        rd_addr = ptr_q[PA_W-1:0];
      end
      ST_WRITE: if (wr_fire && !sec_q) begin
        rd_en   = 1'b1;
        rd_addr = ptr_p1[PA_W-1:0];
      end
      default: ;
    endcase
  end

  // logical write port, driven from registers only
  assign wr_valid = (st_q == ST_CLEAR) || (st_q == ST_WRITE);
  assign wr_addr  = (st_q == ST_CLEAR) ? clr_q : (log_q[LA_W-1:0] + LA_W'(sec_q));
  assign wr_data  = (st_q == ST_CLEAR) ? ERASED : dat_q;

  assign done = (st_q == ST_DONE);
  assign err  = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      ptr_q    <= '0;
      clr_q    <= '0;
      hdr1_q   <= '0;
      blk_q    <= '0;
      absent_q <= '1;
      log_q    <= '0;
      dat_q    <= '0;
      sec_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          err_q <= 1'b0;
          clr_q <= '0;
          st_q  <= ST_CLEAR;
        end
        ST_CLEAR: if (wr_fire) begin
          if (clr_q == LA_W'(LOG_SIZE - 1)) begin
            ptr_q <= '0;
            st_q  <= ST_HDR1;
          end else begin
            clr_q <= clr_q + LA_W'(1);
          end
        end
        ST_HDR1: st_q <= at_limit ? ST_DONE : ST_HDR1_W;
        ST_HDR1_W: begin
          hdr1_q <= rd_data;
          if (dec_end1) begin
            st_q <= ST_DONE;
          end else if (dec_long) begin
            st_q <= hdr2_fits ? ST_HDR2_W : ST_DONE;
          end else begin
            blk_q    <= dec_blk;
            absent_q <= dec_absent;
            ptr_q    <= ptr_p1;
            st_q     <= ST_WORD;
          end
        end
        ST_HDR2_W: begin
          if (dec_end2) begin
            st_q <= ST_DONE;
          end else begin
            blk_q    <= dec_blk;
            absent_q <= dec_absent;
            ptr_q    <= ptr_p2;
            st_q     <= ST_WORD;
          end
        end
        ST_WORD: begin
          if (!pick_any) begin
            st_q <= ST_HDR1;
          end else if (!(data_fits && log_fits)) begin
            err_q <= 1'b1;
            st_q  <= ST_DONE;
          end else begin
            log_q              <= log_addr;
            absent_q[pick_idx] <= 1'b1;
            sec_q              <= 1'b0;
            st_q               <= ST_DATA_W;
          end
        end
        ST_DATA_W: begin
          dat_q <= rd_data;
          st_q  <= ST_WRITE;
        end
        ST_WRITE: if (wr_fire) begin
          if (!sec_q) begin
            sec_q <= 1'b1;
            st_q  <= ST_DATA_W;
          end else begin
            ptr_q <= ptr_p2;
            st_q  <= ST_WORD;
          end
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  a_r11_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  a_r7_read_window: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (int'(rd_addr) < LIMIT));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !$past(start)) |-> $stable(err));

  a_r1_clear_first: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_data != ERASED) |-> (st_q == ST_WRITE));

endmodule

// File: tb/fuse_rec_decoder_test.sv
module fuse_rec_decoder_test;

  localparam int PHY   = 256;
  localparam int PROT  = 16;
  localparam int LOGS  = 128;
  localparam int LIMIT = PHY - PROT;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       done, err, rd_en, wr_valid;
  logic       wr_ready = 1'b1;
  logic [7:0] rd_addr;
  logic [6:0] wr_addr;
  logic [7:0] rd_data, wr_data;

  logic [7:0] pmem [PHY];
  logic [7:0] lmem [LOGS];
  logic [7:0] expm [LOGS];

  int checks = 0, fails = 0;
  int wr_cnt = 0, done_cnt = 0, oob_cnt = 0;

  always #2 clk = ~clk;

  fuse_rec_decoder uut (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .err(err),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  // memory models
  always @(posedge clk) begin
    if (rd_en) rd_data <= pmem[rd_addr];
    if (rd_en && int'(rd_addr) >= LIMIT) oob_cnt++;
    if (wr_valid && wr_ready) begin
      lmem[wr_addr] <= wr_data;
      wr_cnt++;
    end
    if (done) done_cnt++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_map(input string tag);
    int bad;
    bad = -1;
    for (int a = 0; a < LOGS; a++) if (bad < 0 && lmem[a] !== expm[a]) bad = a;
    if (bad < 0) check(1'b1, tag, 0, 0);
    else check(1'b0, {tag, " map byte"}, {bad, 8'h00} | int'(lmem[bad]), {bad, 8'h00} | int'(expm[bad]));
  endtask

  task automatic prep(input logic [7:0] fill);
    for (int a = 0; a < PHY; a++) pmem[a] = fill;
    for (int a = 0; a < LOGS; a++) begin lmem[a] = 8'h00; expm[a] = 8'hFF; end
  endtask

  task automatic run(input bit poke, input bit bp, output bit got_err, output int nwr);
    int cyc;
    wr_cnt = 0; done_cnt = 0; oob_cnt = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    cyc = 0;
    while (!done && cyc < 20000) begin
      cyc++;
      if (poke && cyc == 140) start = 1'b1; else start = 1'b0;
      wr_ready = bp ? (cyc % 3 != 0) : 1'b1;
      @(negedge clk);
    end
    start = 1'b0;
    wr_ready = 1'b1;
    got_err = err;
    repeat (6) @(negedge clk);
    nwr = wr_cnt;
  endtask

  // 80 back-to-back records, 3 bytes each, all to block 0 word 0
  task automatic fill_chain(input int n);
    for (int k = 0; k < n; k++) begin
      pmem[3*k]   = 8'h0E;
      pmem[3*k+1] = 8'(k);
      pmem[3*k+2] = 8'(k) ^ 8'hFF;
    end
  endtask

  task automatic t_reset;
    check(done === 1'b0, "R10 reset done", done, 0);
    check(err === 1'b0, "R10 reset err", err, 0);
    check(wr_valid === 1'b0, "R11 reset wr_valid", wr_valid, 0);
    check(rd_en === 1'b0, "R7 reset rd_en", rd_en, 0);
  endtask

  task automatic t_empty;
    bit e; int n;
    prep(8'hFF);
    run(1'b0, 1'b0, e, n);
    check(e == 1'b0, "R6 erased image err", e, 0);
    check(n == LOGS, "R1 clear write count", n, LOGS);
    check_map("R1 erased map");
  endtask

  task automatic t_short_hdr(input bit bp, input bit poke);
    bit e; int n;
    prep(8'hFF);
    // block 2, flags 1010: words 0 and 2 present (R2, R4)
    pmem[0] = 8'h2A; pmem[1] = 8'h11; pmem[2] = 8'h22; pmem[3] = 8'h33; pmem[4] = 8'h44;
    expm[16] = 8'h11; expm[17] = 8'h22; expm[20] = 8'h33; expm[21] = 8'h44;
    run(poke, bp, e, n);
    check(e == 1'b0, "R2 short header err", e, 0);
    check(n == LOGS + 4, "R10 write count", n, LOGS + 4);
    check(done_cnt == 1, "R10 single done", done_cnt, 1);
    check_map(bp ? "R11 back-pressure map" : "R5 short header map");
  endtask

  task automatic t_long_hdr;
    bit e; int n;
    prep(8'hFF);
    // block {0001,011}=11, word 3 only -> 94/95 (R3, R5)
    pmem[0] = 8'h6F; pmem[1] = 8'h17; pmem[2] = 8'hAA; pmem[3] = 8'hBB;
    pmem[4] = 8'h0E; pmem[5] = 8'hCC; pmem[6] = 8'hDD;
    pmem[7] = 8'h0F; pmem[8] = 8'hFF; pmem[9] = 8'h0E;   // long terminator (R6)
    expm[94] = 8'hAA; expm[95] = 8'hBB; expm[0] = 8'hCC; expm[1] = 8'hDD;
    run(1'b0, 1'b0, e, n);
    check(e == 1'b0, "R6 long terminator err", e, 0);
    check_map("R3 long header map");
  endtask

  task automatic t_log_over;
    bit e; int n;
    prep(8'hFF);
    pmem[0] = 8'h1E; pmem[1] = 8'h55; pmem[2] = 8'h66;
    pmem[3] = 8'h0F; pmem[4] = 8'h2E; pmem[5] = 8'h77; pmem[6] = 8'h88; // block 16 -> 128
    expm[8] = 8'h55; expm[9] = 8'h66;
    run(1'b0, 1'b0, e, n);
    check(e == 1'b1, "R9 logical overflow err", e, 1);
    check_map("R9 overflow word not written");
    repeat (20) @(negedge clk);
    check(err === 1'b1, "R10 err held", err, 1);
  endtask

  task automatic t_at_limit;
    bit e; int n;
    prep(8'h0E);
    fill_chain(80);
    expm[0] = 8'h4F; expm[1] = 8'hB0;
    run(1'b0, 1'b0, e, n);
    check(e == 1'b0, "R7 limit at header err", e, 0);
    check(oob_cnt == 0, "R7 no tail reads", oob_cnt, 0);
    check_map("R7 limit at header map");
  endtask

  task automatic t_straddle;
    bit e; int n;
    prep(8'h00);
    fill_chain(79);
    pmem[237] = 8'h1F; pmem[238] = 8'h1F; pmem[239] = 8'h0F;
    expm[0] = 8'h4E; expm[1] = 8'hB1;
    run(1'b0, 1'b0, e, n);
    check(e == 1'b0, "R7 straddling header err", e, 0);
    check(oob_cnt == 0, "R7 straddle no tail reads", oob_cnt, 0);
    check_map("R7 straddle map");
  endtask

  task automatic t_data_over;
    bit e; int n;
    prep(8'h00);
    fill_chain(79);
    pmem[237] = 8'h0C; pmem[238] = 8'h99; pmem[239] = 8'h77;
    expm[0] = 8'h99; expm[1] = 8'h77;
    run(1'b0, 1'b0, e, n);
    check(e == 1'b1, "R8 data past limit err", e, 1);
    check(oob_cnt == 0, "R8 no tail reads", oob_cnt, 0);
    check_map("R8 partial record map");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int a = 0; a < PHY; a++) pmem[a] = 8'hFF;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_empty;
    t_short_hdr(1'b0, 1'b0);
    t_long_hdr;
    t_log_over;
    t_at_limit;
    check(err === 1'b0, "R10 err cleared by start", err, 0);
    t_straddle;
    t_data_over;
    t_short_hdr(1'b1, 1'b0);
    t_short_hdr(1'b0, 1'b1);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule